// File: doc/BRIEF.md
# Two-Wire Audio Control Register Slave

This block is the control front end of a stereo audio processor. It listens on a two-wire serial bus (I2C) as a write-only target. SCL and SDA are sampled with the system clock. After a START, the first byte must match the fixed 7-bit device address with the write direction bit. The second byte is a subaddress. Its low nibble chooses one of eight function registers, and one flag bit chooses between two modes: repeated writes to one register, or an index that advances with every byte. Each data byte that follows is acknowledged, and where the index allows it, the byte is stored.

The stored settings appear as parallel outputs that the analog path uses: input selection, input gain, volume, bass, treble and two speaker attenuators. After reset they hold fixed values: the second input is selected, gain is high, tone is slightly boosted, and volume and both speakers are muted. The block acknowledges by pulling SDA low through an output-enable pin. It never reads back and never stretches the clock.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the outputs hold in_sel_o=0x02 (code 10 = second input; code 11 = first input), in_gain_o=0x0E, volume_o=0x38 (bits 5..3 all ones = mute), bass_o=0x0E, treble_o=0x0E, spk_right_o=0x78 and spk_left_o=0x78 (bits 6..3 all ones = mute). sda_oe_o is low.
- R2: The address byte must equal 0x88, which is the device address 0x44 shifted left with a 0 write bit. Any other value, including 0x89, is not acknowledged. Neither is any later byte, and nothing is written until the next START.
- R3: Each accepted byte is acknowledged by sda_oe_o high during the ninth SCL pulse. sda_oe_o changes only while the synchronized SCL is low and drops after the ninth falling edge.
- R4: In the subaddress byte, bits 3..0 give the register index and bit 4 is the auto-increment flag. Bits 7..5 have no effect.
- R5: With the flag at 0, every data byte of the transfer goes to the selected register, so the last one is kept.
- R6: With the flag at 1, the first data byte goes to the selected index and each later byte goes to the index plus one. Index 7 is followed by 0, and index 15 is followed by 0.
- R7: Data bytes aimed at indices 8 to 15 are acknowledged but change no output.
- R8: Index 3 is reserved. Data bytes aimed at it are acknowledged but change no output.
- R9: A repeated START at any point, including in the middle of a byte, returns the slave to the address phase with a cleared bit count.
- R10: A STOP releases SDA and returns the slave to idle. Bytes clocked after a STOP without a new START are ignored and not acknowledged.
- R11: Register index map: 0 input select, 1 input gain, 2 volume, 4 bass, 5 treble, 6 right speaker, 7 left speaker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| in_sel_o | output | 8 | Input select register (index 0) |
| in_gain_o | output | 8 | Input gain register (index 1) |
| volume_o | output | 8 | Volume register (index 2) |
| bass_o | output | 8 | Bass register (index 4) |
| treble_o | output | 8 | Treble register (index 5) |
| spk_right_o | output | 8 | Right speaker attenuator (index 6) |
| spk_left_o | output | 8 | Left speaker attenuator (index 7) |

## Verification
The bench keeps the default device address 0x44 and 8-bit data. It builds the synchronizer with three stages instead of two, and each SCL half period lasts eight system clocks. With the deeper synchronizer, the acknowledge still has to be raised and dropped within the low phase, so the bench exercises the real latency margin. The 4-bit index field lets the bench reach the upper half of the index space, the 7-to-0 wrap and the 15-to-0 wrap.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;

  localparam int unsigned NREG    = 8;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned RSV_IDX = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // Power-on contents of each function register (reserved slot reads zero)
  function automatic logic [7:0] por_value(input int unsigned idx);
    case (idx)
      0:       por_value = 8'h02; // second input
      1:       por_value = 8'h0E; // high gain
      2:       por_value = 8'h38; // volume muted
      4:       por_value = 8'h0E; // small bass boost
      5:       por_value = 8'h0E; // small treble boost
      6:       por_value = 8'h78; // right speaker muted
      7:       por_value = 8'h78; // left speaker muted
      default: por_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/acl_line_sync.sv
module acl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/acl_frame_fsm.sv
module acl_frame_fsm
  import audio_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned NREG     = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output phase_t            phase
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DATA_W);
  localparam logic [DATA_W-1:0] MATCH = DATA_W'({DEV_ADDR, 1'b0});
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(NREG - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              ack_q, ack_d;
  logic              oe_q, oe_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              inc_q, inc_d;
  logic              wen_q, wen_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              active;

  assign active = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    idx_d   = idx_q;
    inc_d   = inc_q;
    wen_d   = 1'b0;
    widx_d  = widx_q;
    wdat_d  = wdat_q;
    if (start_det) begin
      phase_d = PH_ADDR;
      bit_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (active) begin
      if (scl_rise && !ack_q && (bit_q < FULL)) begin
        shift_d = {shift_q[DATA_W-2:0], sda_s};
        bit_d   = bit_q + 1'b1;
      end
      if (scl_fall) begin
        if (ack_q) begin
          ack_d = 1'b0;
          oe_d  = 1'b0;
          bit_d = '0;
        end else if (bit_q == FULL) begin
          ack_d = 1'b1;
          oe_d  = 1'b1;
          unique case (phase_q)
            PH_ADDR: begin
              if (shift_q == MATCH) begin
                phase_d = PH_SUB;
              end else begin
                phase_d = PH_SKIP;
                ack_d   = 1'b0;
                oe_d    = 1'b0;
                bit_d   = '0;
              end
            end
            PH_SUB: begin
              idx_d   = shift_q[IDX_W-1:0];
              inc_d   = shift_q[IDX_W];
              phase_d = PH_DATA;
            end
            default: begin
              wen_d  = 1'b1;
              widx_d = idx_q;
              wdat_d = shift_q;
              if (inc_q) begin
                idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      idx_q   <= '0;
      inc_q   <= 1'b0;
      wen_q   <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      idx_q   <= idx_d;
      inc_q   <= inc_d;
      wen_q   <= wen_d;
      widx_q  <= widx_d;
      wdat_q  <= wdat_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_en   = wen_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
  assign phase   = phase_q;

endmodule

// File: rtl/acl_reg_bank.sv
module acl_reg_bank
  import audio_ctl_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned NSLOT   = 8,
  parameter int unsigned RSV_SLOT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NSLOT-1:0][DATA_W-1:0]  regs
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == RSV_SLOT) begin : g_rsv
      assign regs[i] = '0;
    end else begin : g_live
      logic              hit;
      logic [DATA_W-1:0] val_q;
      assign hit = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= DATA_W'(por_value(i));
        end else if (hit) begin
          val_q <= wr_data;
        end
      end
      assign regs[i] = val_q;
    end
  end

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h44,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] in_sel_o,
  output logic [DATA_W-1:0] in_gain_o,
  output logic [DATA_W-1:0] volume_o,
  output logic [DATA_W-1:0] bass_o,
  output logic [DATA_W-1:0] treble_o,
  output logic [DATA_W-1:0] spk_right_o,
  output logic [DATA_W-1:0] spk_left_o
);

  logic                        scl_s, sda_s, scl_rise, scl_fall;
  logic                        start_det, stop_det;
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [DATA_W-1:0]           wr_data;
  phase_t                      phase;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic                        unused_rsv;

  acl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  acl_frame_fsm #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NREG(NREG), .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .phase(phase)
  );

  acl_reg_bank #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NSLOT(NREG), .RSV_SLOT(RSV_IDX)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(regs)
  );

  assign in_sel_o    = regs[0];
  assign in_gain_o   = regs[1];
  assign volume_o    = regs[2];
  assign unused_rsv  = ^regs[RSV_IDX];
  assign bass_o      = regs[4];
  assign treble_o    = regs[5];
  assign spk_right_o = regs[6];
  assign spk_left_o  = regs[7];

endmodule

// File: rtl/acl_slave_chk.sv
module acl_slave_chk
  import audio_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         scl_s,
  input logic                         start_det,
  input logic                         stop_det,
  input logic                         sda_oe,
  input phase_t                       phase,
  input logic                         wr_en,
  input logic [IDX_W-1:0]             wr_idx,
  input logic [NREG-1:0][DATA_W-1:0]  regs
);

  // R3
  oe_edge_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_oe);

  // R9
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == PH_ADDR));

  // R7 R8
  discard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_idx == IDX_W'(RSV_IDX)) || (wr_idx >= IDX_W'(NREG)))) |=> $stable(regs));

endmodule

bind audio_ctl_i2c_slave acl_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .phase(phase), .wr_en(wr_en),
  .wr_idx(wr_idx), .regs(regs)
);

// File: tb/audio_ctl_i2c_slave_bench.sv
`timescale 1ns/1ps
module audio_ctl_i2c_slave_bench;

  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [7:0] o_sel, o_gain, o_vol, o_bass, o_treb, o_spr, o_spl;
  logic [7:0] mdl [0:7];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  audio_ctl_i2c_slave #(.SYNC_STAGES(3)) u_audio_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .in_sel_o(o_sel), .in_gain_o(o_gain),
    .volume_o(o_vol), .bass_o(o_bass), .treble_o(o_treb),
    .spk_right_o(o_spr), .spk_left_o(o_spl)
  );

  function automatic logic [7:0] dut_reg(int i);
    case (i)
      0: dut_reg = o_sel;
      1: dut_reg = o_gain;
      2: dut_reg = o_vol;
      4: dut_reg = o_bass;
      5: dut_reg = o_treb;
      6: dut_reg = o_spr;
      default: dut_reg = o_spl;
    endcase
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req);
    for (int i = 0; i < 8; i++) begin
      if (i != 3) chk8(req, dut_reg(i), mdl[i]);
    end
  endtask

  // Model of a stored write: reserved slot and upper half discard (R7, R8)
  function automatic void mdl_write(int idx, logic [7:0] d);
    if (idx < 8 && idx != 3) mdl[idx] = d;
  endfunction

  task automatic hw();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b0; hw();
    scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw();
    scl_m = 1'b1; hw();
    sda_m = 1'b1; hw();
    hw();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw();
      scl_m = 1'b1; hw();
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1'b1; hw();
    scl_m = 1'b1;
    repeat (HP/2) @(negedge clk);
    acked = ~sda_line;
    repeat (HP/2) @(negedge clk);
    scl_m = 1'b0; hw();
    if (acked) chk8("R3 release after ack", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic byte_exp(string req, logic [7:0] b, logic exp_ack);
    logic a;
    send_byte(b, a);
    chk8(req, {7'd0, a}, {7'd0, exp_ack});
  endtask

  task automatic t_reset();
    chk_regs("R1 reset value");
    chk8("R1 sda idle", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic t_single();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R3 sub ack", 8'h02, 1'b1);
    byte_exp("R5 data ack", 8'h05, 1'b1);
    byte_exp("R5 data ack", 8'h11, 1'b1);
    byte_exp("R5 data ack", 8'h2A, 1'b1);
    bus_stop();
    mdl_write(2, 8'h2A);
    chk_regs("R5 same register");
  endtask

  task automatic t_wrap();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R6 sub ack", 8'h15, 1'b1);
    for (int k = 0; k < 5; k++) begin
      byte_exp("R6 data ack", 8'hA1 + 8'(k), 1'b1);
      mdl_write((5 + k) % 8, 8'hA1 + 8'(k));
    end
    bus_stop();
    chk_regs("R6 R11 auto-increment 7 to 0");
  endtask

  task automatic t_reserved();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R8 sub ack", 8'h12, 1'b1);
    byte_exp("R8 data ack", 8'h33, 1'b1);
    byte_exp("R8 reserved ack", 8'h44, 1'b1);
    byte_exp("R8 data ack", 8'h55, 1'b1);
    bus_stop();
    mdl_write(2, 8'h33); mdl_write(3, 8'h44); mdl_write(4, 8'h55);
    chk_regs("R8 reserved skipped");
  endtask

  task automatic t_upper();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R7 sub ack", 8'h0A, 1'b1);
    byte_exp("R7 upper ack", 8'h99, 1'b1);
    byte_exp("R7 upper ack", 8'h98, 1'b1);
    bus_stop();
    chk_regs("R7 upper ignored");
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R6 sub ack", 8'h1E, 1'b1);
    byte_exp("R7 idx14 ack", 8'h60, 1'b1);
    byte_exp("R7 idx15 ack", 8'h61, 1'b1);
    byte_exp("R6 idx0 ack", 8'h62, 1'b1);
    bus_stop();
    mdl_write(0, 8'h62);
    chk_regs("R6 R7 wrap 15 to 0");
  endtask

  task automatic t_topbits();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R4 sub ack", 8'hE1, 1'b1);
    byte_exp("R4 data ack", 8'h07, 1'b1);
    byte_exp("R4 data ack", 8'h09, 1'b1);
    bus_stop();
    mdl_write(1, 8'h09);
    chk_regs("R4 bits 7..5 ignored, flag clear");
  endtask

  task automatic t_badaddr();
    bus_start();
    byte_exp("R2 wrong address nack", 8'h8A, 1'b0);
    byte_exp("R2 later byte nack", 8'h02, 1'b0);
    byte_exp("R2 later byte nack", 8'hFF, 1'b0);
    bus_stop();
    bus_start();
    byte_exp("R2 read bit nack", 8'h89, 1'b0);
    byte_exp("R2 later byte nack", 8'h07, 1'b0);
    byte_exp("R2 later byte nack", 8'h00, 1'b0);
    bus_stop();
    chk_regs("R2 nothing written");
  endtask

  task automatic t_restart();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R9 sub ack", 8'h00, 1'b1);
    bus_start();
    byte_exp("R9 address after restart", 8'h88, 1'b1);
    byte_exp("R9 sub ack", 8'h04, 1'b1);
    byte_exp("R9 data ack", 8'h3C, 1'b1);
    bus_start();
    byte_exp("R9 address ack", 8'h88, 1'b1);
    send_bits(8'hC0, 3);
    bus_start();
    byte_exp("R9 address after mid-byte restart", 8'h88, 1'b1);
    byte_exp("R9 sub ack", 8'h05, 1'b1);
    byte_exp("R9 data ack", 8'h4D, 1'b1);
    bus_stop();
    mdl_write(4, 8'h3C); mdl_write(5, 8'h4D);
    chk_regs("R9 restart");
  endtask

  task automatic t_stop();
    bus_start();
    byte_exp("R2 address ack", 8'h88, 1'b1);
    byte_exp("R10 sub ack", 8'h02, 1'b1);
    bus_stop();
    chk8("R10 sda released", {7'd0, sda_oe}, 8'd0);
    byte_exp("R10 no ack after stop", 8'h88, 1'b0);
    byte_exp("R10 no ack after stop", 8'h77, 1'b0);
    bus_stop();
    chk_regs("R10 idle ignores bus");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h02; mdl[1] = 8'h0E; mdl[2] = 8'h38; mdl[4] = 8'h0E;
    mdl[5] = 8'h0E; mdl[6] = 8'h78; mdl[7] = 8'h78;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_reserved();
    t_upper();
    t_topbits();
    t_badaddr();
    t_restart();
    t_stop();
    summary();
  end

endmodule